// File: doc/BRIEF.md
# Transition-Filtered Status Register

This block keeps one level of an instrument-style status hierarchy. Every clock it samples a hardware condition vector and finds which bits have just risen or fallen. Two programmable masks decide, bit by bit, which edges count: rising only, falling only, both or neither. Each edge that passes its mask sets a sticky event bit. The event bits stay set until software reads the event part or issues a clear-status strobe.

A third mask, the enable mask, selects which event bits take part in a single summary output. The summary is the OR of event AND enable over all bits. It is combinational, so a parent register of the same kind can take it straight into one of its own condition inputs. Software uses a small register-access port. A 3-bit part selector chooses the part, with read and write strobes. The read data follows the selector without any strobe, so a plain look at the read data has no side effect. The read strobe matters only for the event part, where it clears the events.

Part selector codes: 0 = condition, 1 = rising-edge mask, 2 = falling-edge mask, 3 = event, 4 = enable. Codes 5 to 7 read as zero, and writes to them are ignored.

Top module: `evt_status_reg`

## Requirements
- R1: After reset the condition history, event and enable parts read 0, the rising-edge mask reads 0x7FFF and the falling-edge mask reads 0 (width 16).
- R2: Bit 15, the top bit, of every part always reads 0. A write of 1 to bit 15 of any mask is dropped.
- R3: The condition part (code 0) reads the condition input as sampled at the most recent clock edge. Writes to code 0 and the clear-status strobe do not change it.
- R4: A condition bit that goes from 0 to 1 between two clock edges sets its event bit at the second edge only if its rising-edge mask bit (code 1) is 1.
- R5: A condition bit that goes from 1 to 0 sets its event bit only if its falling-edge mask bit (code 2) is 1. With both mask bits at 1, either edge sets the event.
- R6: Event bits stay set while neither an event-part read strobe nor the clear-status strobe is applied.
- R7: A read strobe on code 3 returns the event value from before the clear, and clears all event bits at that clock edge.
- R8: The clear-status strobe clears all event bits and leaves the rising mask, falling mask and enable mask unchanged.
- R9: An edge that passes its mask in the same cycle as a clear (by strobe or by event read) is kept. Setting wins over clearing.
- R10: The summary output equals the OR over all bits of event AND enable, in the same cycle. It is 0 whenever the enable mask is 0.
- R11: The rising-edge mask, falling-edge mask and enable mask (codes 1, 2, 4) read back what was written, with bit 15 forced to 0. Reading them, with or without the read strobe, does not change them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_in | input | 16 | Live hardware condition vector |
| acc_rd | input | 1 | Read strobe. On code 3 it clears the events |
| acc_wr | input | 1 | Write strobe |
| acc_addr | input | 3 | Part selector |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data of the selected part (combinational) |
| clr_status | input | 1 | Clear-status strobe |
| summary_out | output | 1 | Enable-masked OR of the event bits |

## Verification
The hardest situation to reach is an edge that passes its mask in the very cycle that clears the events. Only then is the set-over-clear priority visible. The bench reaches it by driving a condition change, a clear-status strobe and, separately, an event-read strobe onto the same clock edge. It then checks that only the new bit survives and that the read returned the older value. Around this, a sweep covers every usable bit against all four mask combinations and both edge directions. The expected event and summary values are computed arithmetically from the bit index.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
   localparam int unsigned SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      PART_COND   = 3'd0,
      PART_RISE   = 3'd1,
      PART_FALL   = 3'd2,
      PART_EVENT  = 3'd3,
      PART_ENABLE = 3'd4
   } part_sel_e;
endpackage

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
   parameter int unsigned    WIDTH     = 16,
   parameter logic [WIDTH-1:0] RESET_VAL = '0,
   parameter logic [WIDTH-1:0] KEEP      = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RESET_VAL & KEEP;
      else if (wr_en) q <= wdata & KEEP;
   end
endmodule

// File: rtl/evt_edge_qual.sv
module evt_edge_qual #(
   parameter int unsigned      WIDTH = 16,
   parameter logic [WIDTH-1:0] KEEP  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cond_in,
   input  logic [WIDTH-1:0] rise_mask,
   input  logic [WIDTH-1:0] fall_mask,
   output logic [WIDTH-1:0] cond_q,
   output logic [WIDTH-1:0] hit
);
   logic [WIDTH-1:0] cond_m;
   assign cond_m = cond_in & KEEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= '0;
      else        cond_q <= cond_m;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic went_up, went_down;
      assign went_up   = cond_m[i] & ~cond_q[i];
      assign went_down = ~cond_m[i] & cond_q[i];
      assign hit[i]    = (went_up & rise_mask[i]) | (went_down & fall_mask[i]);
   end
endmodule

// File: rtl/evt_event_hold.sv
module evt_event_hold #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic             clr,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= set_vec;
      else          q <= q | set_vec;
   end
endmodule

// File: rtl/evt_summary.sv
module evt_summary #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] event_vec,
   input  logic [WIDTH-1:0] enable_vec,
   output logic             sum_out
);
   logic [WIDTH:0] chain;
   assign chain[0] = 1'b0;
   for (genvar i = 0; i < WIDTH; i++) begin : g_or
      assign chain[i+1] = chain[i] | (event_vec[i] & enable_vec[i]);
   end
   assign sum_out = chain[WIDTH];
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
   import evt_status_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cond_in,
   input  logic             acc_rd,
   input  logic             acc_wr,
   input  logic [2:0]       acc_addr,
   input  logic [WIDTH-1:0] acc_wdata,
   output logic [WIDTH-1:0] acc_rdata,
   input  logic             clr_status,
   output logic             summary_out
);
   localparam logic [WIDTH-1:0] KEEP      = {1'b0, {(WIDTH-1){1'b1}}};
   localparam logic [WIDTH-1:0] RISE_INIT = KEEP;

   if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
      $error("evt_status_reg: WIDTH must lie in 2..32");
   end

   part_sel_e        sel;
   logic [WIDTH-1:0] cond_q, rise_q, fall_q, event_q, enable_q, hit;
   logic             wr_rise, wr_fall, wr_enable, event_clr;

   assign sel       = part_sel_e'(acc_addr);
   assign wr_rise   = acc_wr && (sel == PART_RISE);
   assign wr_fall   = acc_wr && (sel == PART_FALL);
   assign wr_enable = acc_wr && (sel == PART_ENABLE);
   assign event_clr = clr_status || (acc_rd && (sel == PART_EVENT));

   evt_mask_reg #(.WIDTH(WIDTH), .RESET_VAL(RISE_INIT), .KEEP(KEEP)) u_rise (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_rise), .wdata(acc_wdata), .q(rise_q));

   evt_mask_reg #(.WIDTH(WIDTH), .RESET_VAL('0), .KEEP(KEEP)) u_fall (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_fall), .wdata(acc_wdata), .q(fall_q));

   evt_mask_reg #(.WIDTH(WIDTH), .RESET_VAL('0), .KEEP(KEEP)) u_enable (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_enable), .wdata(acc_wdata), .q(enable_q));

   evt_edge_qual #(.WIDTH(WIDTH), .KEEP(KEEP)) u_edge (
      .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .rise_mask(rise_q),
      .fall_mask(fall_q), .cond_q(cond_q), .hit(hit));

   evt_event_hold #(.WIDTH(WIDTH)) u_event (
      .clk(clk), .rst_n(rst_n), .set_vec(hit), .clr(event_clr), .q(event_q));

   evt_summary #(.WIDTH(WIDTH)) u_sum (
      .event_vec(event_q), .enable_vec(enable_q), .sum_out(summary_out));

   always_comb begin
      unique case (sel)
         PART_COND:   acc_rdata = cond_q;
         PART_RISE:   acc_rdata = rise_q;
         PART_FALL:   acc_rdata = fall_q;
         PART_EVENT:  acc_rdata = event_q;
         PART_ENABLE: acc_rdata = enable_q;
         default:     acc_rdata = '0;
      endcase
   end
endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] cond_in,
   input logic             acc_rd,
   input logic             acc_wr,
   input logic [2:0]       acc_addr,
   input logic [WIDTH-1:0] acc_rdata,
   input logic             clr_status,
   input logic             summary_out,
   input logic [WIDTH-1:0] cond_q,
   input logic [WIDTH-1:0] rise_q,
   input logic [WIDTH-1:0] fall_q,
   input logic [WIDTH-1:0] event_q,
   input logic [WIDTH-1:0] enable_q
);
   localparam logic [WIDTH-1:0] KEEP = {1'b0, {(WIDTH-1){1'b1}}};

   logic [WIDTH-1:0] up_ok, down_ok;
   logic             any_clear;
   assign up_ok     = cond_in & KEEP & ~cond_q & rise_q;
   assign down_ok   = ~(cond_in & KEEP) & cond_q & fall_q;
   assign any_clear = clr_status || (acc_rd && acc_addr == 3'd3);

   assert_msb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rdata[WIDTH-1] && !rise_q[WIDTH-1] && !fall_q[WIDTH-1] && !enable_q[WIDTH-1]);

   assert_cond_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cond_q == ($past(cond_in) & KEEP));

   assert_rise_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_ok != '0) |=> ((event_q & $past(up_ok)) == $past(up_ok)));

   assert_fall_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (down_ok != '0) |=> ((event_q & $past(down_ok)) == $past(down_ok)));

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !any_clear |=> (($past(event_q) & ~event_q) == '0));

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any_clear |=> event_q == $past(up_ok | down_ok));

   assert_clear_keeps_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_status && !acc_wr) |=> ($stable(enable_q) && $stable(rise_q) && $stable(fall_q)));

   assert_summary_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q == '0) |-> !summary_out);

   assert_summary_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((event_q & enable_q) != '0) |-> summary_out);
endmodule

bind evt_status_reg evt_status_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_evt_status_reg.sv
module sim_evt_status_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cond_in = '0;
   logic        acc_rd = 1'b0, acc_wr = 1'b0, clr_status = 1'b0;
   logic [2:0]  acc_addr = '0;
   logic [15:0] acc_wdata = '0;
   logic [15:0] acc_rdata;
   logic        summary_out;

   int n_tests = 0;
   int n_fail  = 0;

   evt_status_reg #(.WIDTH(16)) u0 (
      .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .acc_rd(acc_rd), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .clr_status(clr_status), .summary_out(summary_out));

   always #4 clk = ~clk;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic peek(input logic [2:0] a, output logic [15:0] v);
      acc_addr = a;
      #1;
      v = acc_rdata;
   endtask

   task automatic write(input logic [2:0] a, input logic [15:0] d);
      acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
      step();
      acc_wr = 1'b0;
   endtask

   task automatic read_strobe(input logic [2:0] a, output logic [15:0] v);
      acc_addr = a; acc_rd = 1'b1;
      #1;
      v = acc_rdata;
      step();
      acc_rd = 1'b0;
   endtask

   task automatic clear();
      clr_status = 1'b1;
      step();
      clr_status = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] v, w;
      step(); step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      peek(3'd0, v); check("R1 cond", v, 16'h0000);
      peek(3'd1, v); check("R1 rise", v, 16'h7FFF);
      peek(3'd2, v); check("R1 fall", v, 16'h0000);
      peek(3'd3, v); check("R1 event", v, 16'h0000);
      peek(3'd4, v); check("R1 enable", v, 16'h0000);
      check("R1 summary", {15'd0, summary_out}, 16'h0000);

      // R2 / R11 top bit dropped, readback
      write(3'd1, 16'hFFFF); peek(3'd1, v); check("R2 rise msb", v, 16'h7FFF);
      write(3'd2, 16'hFFFF); peek(3'd2, v); check("R2 fall msb", v, 16'h7FFF);
      write(3'd4, 16'hFFFF); peek(3'd4, v); check("R2 enable msb", v, 16'h7FFF);
      write(3'd4, 16'h1234); read_strobe(3'd4, v); check("R11 enable read", v, 16'h1234);
      peek(3'd4, v); check("R11 enable after read", v, 16'h1234);
      write(3'd1, 16'h0A5A); read_strobe(3'd1, v); peek(3'd1, w); check("R11 rise read", w, 16'h0A5A);
      write(3'd2, 16'h50A5); read_strobe(3'd2, v); peek(3'd2, w); check("R11 fall read", w, 16'h50A5);
      write(3'd5, 16'hFFFF); peek(3'd5, v); check("R11 unused code", v, 16'h0000);

      // R3 condition tracking and read-only
      write(3'd1, 16'h0000); write(3'd2, 16'h0000);
      cond_in = 16'hFFFF; step();
      peek(3'd0, v); check("R3 cond msb", v, 16'h7FFF);
      write(3'd0, 16'h0000); peek(3'd0, v); check("R3 cond write", v, 16'h7FFF);
      clear(); peek(3'd0, v); check("R3 cond clear", v, 16'h7FFF);
      cond_in = 16'h2468; step(); peek(3'd0, v); check("R3 cond follow", v, 16'h2468);
      cond_in = 16'h0000; step();
      peek(3'd3, v); check("R3 no events with masks off", v, 16'h0000);

      // R4 / R5 / R6 / R10 sweep: every bit x every mask combination
      for (int b = 0; b < 15; b++) begin
         for (int m = 0; m < 4; m++) begin
            logic [15:0] bit_v, exp_up, exp_all;
            bit_v   = 16'h1 << b;
            exp_up  = m[0] ? bit_v : 16'h0;
            exp_all = (m != 0) ? bit_v : 16'h0;
            write(3'd1, m[0] ? bit_v : 16'h0);
            write(3'd2, m[1] ? bit_v : 16'h0);
            write(3'd4, bit_v);
            clear();
            cond_in = bit_v; step();
            peek(3'd3, v); check("R4 rising filter", v, exp_up);
            cond_in = 16'h0; step();
            peek(3'd3, v); check("R5 falling filter", v, exp_all);
            step(); step();
            peek(3'd3, v); check("R6 sticky", v, exp_all);
            check("R10 summary", {15'd0, summary_out}, {15'd0, exp_all != 0});
         end
      end

      // R10 enable off gates summary
      write(3'd1, 16'h7FFF); clear();
      cond_in = 16'h0101; step();
      write(3'd4, 16'h0000);
      check("R10 summary gated", {15'd0, summary_out}, 16'h0000);
      write(3'd4, 16'h0100);
      check("R10 summary enabled", {15'd0, summary_out}, 16'h0001);

      // R7 read returns old then clears
      read_strobe(3'd3, v); check("R7 read value", v, 16'h0101);
      peek(3'd3, v); check("R7 cleared", v, 16'h0000);
      check("R7 summary after clear", {15'd0, summary_out}, 16'h0000);

      // R8 clear leaves masks
      write(3'd2, 16'h0F0F); write(3'd4, 16'h3C3C);
      cond_in = 16'h0000; step();
      peek(3'd3, v); check("R8 setup event", v, 16'h0101);
      clear();
      peek(3'd3, v); check("R8 event cleared", v, 16'h0000);
      peek(3'd1, v); check("R8 rise kept", v, 16'h7FFF);
      peek(3'd2, v); check("R8 fall kept", v, 16'h0F0F);
      peek(3'd4, v); check("R8 enable kept", v, 16'h3C3C);

      // R9 set wins over clear strobe
      cond_in = 16'h0020; step();
      clr_status = 1'b1; cond_in = 16'h0028; step(); clr_status = 1'b0;
      peek(3'd3, v); check("R9 clear vs edge", v, 16'h0008);

      // R9 set wins over event read, read sees old value
      acc_addr = 3'd3; acc_rd = 1'b1; cond_in = 16'h0428; #1; v = acc_rdata;
      step(); acc_rd = 1'b0;
      check("R9 read old value", v, 16'h0008);
      peek(3'd3, v); check("R9 read vs edge", v, 16'h0400);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule